// File: doc/BRIEF.md
# Banked Bit-Addressable Scratchpad RAM

This block is the internal data memory of a small 8-bit accumulator CPU. A 256-byte array sits behind one request port. The same bytes can be reached in four ways: as a banked working register, by a direct byte address, by an indirect byte address, or as a single bit. These views overlap. A register number is placed inside one of four eight-byte banks at the bottom of the array. A bit address selects one bit inside a sixteen-byte window that starts at byte 20h. A direct address in the upper half does not reach the array at all. It is flagged so that the special-register file, which lives elsewhere, can take the access.

A bit that is set, cleared or written is updated by an internal read-modify-write. The request port therefore drops its ready for one cycle after such an operation. A second, independent port serves external-data moves. It steers them either to an on-chip 1 KB array or out to the external bus. The choice depends on a select bit and on a 2-bit field that sets how much of the on-chip array may be used. Neither array is cleared by reset.

Top module: `iram_scratchpad`

## Requirements
- R1: With `req_kind` = 00 (register), the access reaches byte `bank*8 + req_addr[2:0]`. Bank 0 covers bytes 00h–07h, bank 1 covers 08h–0Fh, bank 2 covers 10h–17h and bank 3 covers 18h–1Fh.
- R2: With `req_kind` = 10 (indirect), any byte 00h–FFh is read or written. With `req_kind` = 01 (direct), bytes 00h–7Fh are the same storage that indirect access reaches.
- R3: A direct access (`req_kind` = 01) with `req_addr[7]` = 1 raises `sfr_hit` in its accept cycle. It writes no byte of the array and produces no `rd_valid`.
- R4: With `req_kind` = 11 (bit), bit address b (`req_addr[6:0]`) maps to byte 20h + b[6:3], bit b[2:0]. A bit read (`req_bitop` = 00) returns that bit on `rd_bit`, and the whole byte on `rd_data`, one cycle after acceptance.
- R5: The bit operations are `req_bitop` = 01 (set), 10 (clear) and 11 (write `req_wbit`). Each changes only the addressed bit of its byte.
- R6: In the cycle after a bit set, clear or write is accepted, `req_ready` is 0 and no request is accepted. In the cycle after that, `req_ready` is 1 again.
- R7: A byte or bit read that is accepted on one clock edge shows `rd_valid` = 1 and its data after that edge, for one cycle. A value that is written can be read by the very next request.
- R8: With `x_extram` = 1, every external-data access raises `ext_req` and leaves the on-chip 1 KB array untouched.
- R9: With `x_extram` = 0, an address is served on chip only if it is below 1024 and `x_addr[9:8]` <= `x_size`. The `x_size` encoding is 00 = 256 B, 01 = 512 B, 10 = 768 B and 11 = 1024 B. All other addresses raise `ext_req`.
- R10: An on-chip external-data read shows `x_rd_valid` and `x_rd_data` one cycle after its request. A routed-out access gives no `x_rd_valid`.
- R11: After reset, `req_ready` = 1, `rd_valid` = 0 and `x_rd_valid` = 0. The bytes held in both arrays keep their values across a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Internal access request |
| req_ready | output | 1 | Request port can accept this cycle |
| req_kind | input | 2 | 00 register, 01 direct, 10 indirect, 11 bit |
| req_addr | input | 8 | Register number, byte address or bit address |
| req_bank | input | 2 | Register bank select |
| req_we | input | 1 | Byte write (register, direct and indirect kinds) |
| req_wdata | input | 8 | Byte write data |
| req_bitop | input | 2 | Bit operation: 00 read, 01 set, 10 clear, 11 write |
| req_wbit | input | 1 | Value for a bit write |
| sfr_hit | output | 1 | Direct access to 80h–FFh handed to the special-register space |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read byte |
| rd_bit | output | 1 | Addressed bit of a bit read |
| x_valid | input | 1 | External-data access request |
| x_we | input | 1 | External-data write |
| x_addr | input | 16 | External-data address |
| x_wdata | input | 8 | External-data write byte |
| x_extram | input | 1 | 1 sends all external-data accesses to the bus |
| x_size | input | 2 | On-chip expanded array size field |
| ext_req | output | 1 | Access routed to the external bus |
| ext_we | output | 1 | Routed access is a write |
| x_rd_valid | output | 1 | On-chip expanded read data valid |
| x_rd_data | output | 8 | On-chip expanded read byte |

## Verification
The internal request port and the external-data port are separate, so an internal access and an expanded-array access can fall in the same cycle. The bench provokes this in two ways. It issues an indirect read together with an on-chip expanded read of the same low address. It also starts a bit write in the same cycle as an expanded write. Both results are then checked against separate reference arrays in the bench: each port must return only its own array's byte, and neither write may disturb the other array. The stall cycle of the read-modify-write is also checked while the expanded port keeps running.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    KIND_REG = 2'b00,
    KIND_DIR = 2'b01,
    KIND_IND = 2'b10,
    KIND_BIT = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    BOP_RD  = 2'b00,
    BOP_SET = 2'b01,
    BOP_CLR = 2'b10,
    BOP_WR  = 2'b11
  } bit_op_e;
endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
#(
  parameter int AW = 8,
  parameter int BANK_W = 2,
  parameter int REG_W = 3,
  parameter logic [AW-1:0] BIT_BASE = 'h20
) (
  input  logic [1:0]        kind,
  input  logic [AW-1:0]     addr,
  input  logic [BANK_W-1:0] bank,
  output logic [AW-1:0]     byte_addr,
  output logic [2:0]        bit_pos,
  output logic              to_sfr
);
  // Bank-relative register placement and bit-packed alias window.
  always_comb begin
    byte_addr = addr;
    bit_pos   = addr[2:0];
    to_sfr    = 1'b0;
    case (acc_kind_e'(kind))
      KIND_REG: byte_addr = AW'({bank, addr[REG_W-1:0]});
      KIND_DIR: to_sfr = addr[AW-1];
      KIND_IND: byte_addr = addr;
      KIND_BIT: byte_addr = BIT_BASE + AW'(addr[AW-2:3]);
      default:  byte_addr = addr;
    endcase
  end
endmodule

// File: rtl/iram_array.sv
module iram_array #(
  parameter int DW = 8,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  // Volatile storage: no reset, contents survive a reset pulse.
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/iram_bit_rmw.sv
module iram_bit_rmw
  import iram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int PW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [PW-1:0] pos,
  input  logic          wbit,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rdata,
  output logic          busy,
  output logic          wb_en,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data
);
  typedef enum logic {S_IDLE, S_WB} st_e;
  st_e st_q, st_d;

  logic [AW-1:0] addr_q;
  logic [PW-1:0] pos_q;
  logic [1:0]    op_q;
  logic          wbit_q;
  logic [DW-1:0] mask;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (start) st_d = S_WB;
      S_WB:    st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (start) begin
      addr_q <= addr;
      pos_q  <= pos;
      op_q   <= op;
      wbit_q <= wbit;
    end
  end

  // Merge the fetched byte with the single-bit change.
  always_comb begin
    mask = DW'(1) << pos_q;
    case (bit_op_e'(op_q))
      BOP_SET: wb_data = rdata | mask;
      BOP_CLR: wb_data = rdata & ~mask;
      BOP_WR:  wb_data = wbit_q ? (rdata | mask) : (rdata & ~mask);
      default: wb_data = rdata;
    endcase
  end

  assign busy    = (st_q == S_WB);
  assign wb_en   = busy;
  assign wb_addr = addr_q;
endmodule

// File: rtl/xram_router.sv
module xram_router #(
  parameter int XADDR_W = 16,
  parameter int DEPTH = 1024,
  parameter int SIZE_W = 2,
  parameter int DW = 8,
  localparam int XAW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               x_valid,
  input  logic               x_we,
  input  logic [XADDR_W-1:0] x_addr,
  input  logic [DW-1:0]      x_wdata,
  input  logic               extram,
  input  logic [SIZE_W-1:0]  size,
  output logic               ext_req,
  output logic               ext_we,
  output logic               x_rd_valid,
  output logic [DW-1:0]      x_rd_data
);
  logic              hi_zero;
  logic [SIZE_W-1:0] page;
  logic              on_chip;
  logic              rdv_d;

  assign hi_zero = (x_addr[XADDR_W-1:XAW] == '0);
  assign page    = x_addr[XAW-1 -: SIZE_W];
  assign on_chip = x_valid & ~extram & hi_zero & (page <= size);
  assign ext_req = x_valid & ~on_chip;
  assign ext_we  = ext_req & x_we;
  assign rdv_d   = on_chip & ~x_we;

  iram_array #(.DW(DW), .DEPTH(DEPTH)) xarr_i (
    .clk   (clk),
    .re    (rdv_d),
    .raddr (x_addr[XAW-1:0]),
    .rdata (x_rd_data),
    .we    (on_chip & x_we),
    .waddr (x_addr[XAW-1:0]),
    .wdata (x_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_rd_valid <= 1'b0;
    else        x_rd_valid <= rdv_d;
  end
endmodule

// File: rtl/iram_scratchpad.sv
module iram_scratchpad
  import iram_pkg::*;
#(
  parameter int IRAM_DEPTH = 256,
  parameter int BANK_W = 2,
  parameter int REG_W = 3,
  parameter logic [7:0] BIT_BASE = 8'h20,
  parameter int XRAM_DEPTH = 1024,
  parameter int XADDR_W = 16,
  parameter int XSIZE_W = 2,
  localparam int IAW = $clog2(IRAM_DEPTH),
  localparam int DW = BYTE_W,
  localparam int PW = $clog2(BYTE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [IAW-1:0]     req_addr,
  input  logic [BANK_W-1:0]  req_bank,
  input  logic               req_we,
  input  logic [DW-1:0]      req_wdata,
  input  logic [1:0]         req_bitop,
  input  logic               req_wbit,
  output logic               sfr_hit,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data,
  output logic               rd_bit,
  input  logic               x_valid,
  input  logic               x_we,
  input  logic [XADDR_W-1:0] x_addr,
  input  logic [DW-1:0]      x_wdata,
  input  logic               x_extram,
  input  logic [XSIZE_W-1:0] x_size,
  output logic               ext_req,
  output logic               ext_we,
  output logic               x_rd_valid,
  output logic [DW-1:0]      x_rd_data
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  logic [IAW-1:0] map_addr;
  logic [2:0]     map_pos;
  logic           to_sfr;

  iram_addr_map #(.AW(IAW), .BANK_W(BANK_W), .REG_W(REG_W), .BIT_BASE(BIT_BASE)) map_i (
    .kind      (req_kind),
    .addr      (req_addr),
    .bank      (req_bank),
    .byte_addr (map_addr),
    .bit_pos   (map_pos),
    .to_sfr    (to_sfr)
  );

  logic           busy, accept, is_bit, bit_mod;
  logic           mem_re, rq_we, rd_d;
  logic           wb_en;
  logic [IAW-1:0] wb_addr;
  logic [DW-1:0]  wb_data;
  logic [PW-1:0]  pos_q;

  assign req_ready = ~busy;
  assign accept    = req_valid & ~busy;
  assign is_bit    = (req_kind == KIND_BIT);
  assign bit_mod   = is_bit & (req_bitop != BOP_RD);
  assign mem_re    = accept & ~to_sfr & (is_bit | ~req_we);
  assign rq_we     = accept & ~to_sfr & ~is_bit & req_we;
  assign rd_d      = mem_re & ~bit_mod;
  assign sfr_hit   = accept & to_sfr;

  iram_bit_rmw #(.AW(IAW), .DW(DW)) rmw_i (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .start   (accept & bit_mod),
    .op      (req_bitop),
    .pos     (map_pos[PW-1:0]),
    .wbit    (req_wbit),
    .addr    (map_addr),
    .rdata   (rd_data),
    .busy    (busy),
    .wb_en   (wb_en),
    .wb_addr (wb_addr),
    .wb_data (wb_data)
  );

  iram_array #(.DW(DW), .DEPTH(IRAM_DEPTH)) iarr_i (
    .clk   (clk),
    .re    (mem_re),
    .raddr (map_addr),
    .rdata (rd_data),
    .we    (wb_en | rq_we),
    .waddr (wb_en ? wb_addr : map_addr),
    .wdata (wb_en ? wb_data : req_wdata)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) rd_valid <= 1'b0;
    else          rd_valid <= rd_d;
  end

  always_ff @(posedge clk) begin
    if (rd_d) pos_q <= map_pos[PW-1:0];
  end

  assign rd_bit = rd_data[pos_q];

  xram_router #(.XADDR_W(XADDR_W), .DEPTH(XRAM_DEPTH), .SIZE_W(XSIZE_W), .DW(DW)) xr_i (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .x_valid    (x_valid),
    .x_we       (x_we),
    .x_addr     (x_addr),
    .x_wdata    (x_wdata),
    .extram     (x_extram),
    .size       (x_size),
    .ext_req    (ext_req),
    .ext_we     (ext_we),
    .x_rd_valid (x_rd_valid),
    .x_rd_data  (x_rd_data)
  );
endmodule

// File: rtl/iram_scratchpad_chk.sv
module iram_scratchpad_chk #(
  parameter int XADDR_W = 16
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_kind,
  input logic               req_we,
  input logic [1:0]         req_bitop,
  input logic               sfr_hit,
  input logic               rd_valid,
  input logic               x_valid,
  input logic               x_we,
  input logic [XADDR_W-1:0] x_addr,
  input logic               x_extram,
  input logic               ext_req,
  input logic               x_rd_valid
);
  p_bitwr_stall_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready && req_kind == 2'b11 && req_bitop != 2'b00) |=> !req_ready);

  p_stall_once_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_ready |=> req_ready);

  p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready && !sfr_hit &&
     ((req_kind == 2'b11) ? (req_bitop == 2'b00) : !req_we)) |=> rd_valid);

  p_no_spurious_rd_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !(req_valid && req_ready) |=> !rd_valid);

  p_sfr_no_data_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    sfr_hit |=> !rd_valid);

  p_extram_out_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (x_valid && x_extram) |-> ext_req);

  p_low_page_local_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (x_valid && !x_extram && x_addr < XADDR_W'(256)) |-> !ext_req);

  p_xrd_latency_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (x_valid && !x_we && !ext_req) |=> x_rd_valid);

  p_xrd_none_ext_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    ext_req |=> !x_rd_valid);
endmodule

bind iram_scratchpad iram_scratchpad_chk #(.XADDR_W(XADDR_W)) chk_i (
  .clk        (clk),
  .rst_ni     (rst_q_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_kind   (req_kind),
  .req_we     (req_we),
  .req_bitop  (req_bitop),
  .sfr_hit    (sfr_hit),
  .rd_valid   (rd_valid),
  .x_valid    (x_valid),
  .x_we       (x_we),
  .x_addr     (x_addr),
  .x_extram   (x_extram),
  .ext_req    (ext_req),
  .x_rd_valid (x_rd_valid)
);

// File: tb/iram_scratchpad_tb_top.sv
module iram_scratchpad_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_we, req_wbit;
  logic [1:0]  req_kind, req_bank, req_bitop;
  logic [7:0]  req_addr, req_wdata;
  logic        sfr_hit, rd_valid, rd_bit;
  logic [7:0]  rd_data;
  logic        x_valid, x_we, x_extram;
  logic [15:0] x_addr;
  logic [7:0]  x_wdata, x_rd_data;
  logic [1:0]  x_size;
  logic        ext_req, ext_we, x_rd_valid;

  always #2 clk = ~clk;

  iram_scratchpad dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_bank(req_bank), .req_we(req_we),
    .req_wdata(req_wdata), .req_bitop(req_bitop), .req_wbit(req_wbit),
    .sfr_hit(sfr_hit), .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit(rd_bit),
    .x_valid(x_valid), .x_we(x_we), .x_addr(x_addr), .x_wdata(x_wdata),
    .x_extram(x_extram), .x_size(x_size), .ext_req(ext_req), .ext_we(ext_we),
    .x_rd_valid(x_rd_valid), .x_rd_data(x_rd_data)
  );

  int vecs = 0;
  int errs = 0;
  logic [7:0] model  [256];
  logic [7:0] xmodel [1024];
  logic seen_sfr, seen_ready, seen_ext;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic ireq(input logic [1:0] k, input logic [7:0] a, input logic [1:0] bk,
                      input logic w, input logic [7:0] d, input logic [1:0] bo, input logic wb);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_bank = bk;
    req_we = w; req_wdata = d; req_bitop = bo; req_wbit = wb;
    #1 seen_sfr = sfr_hit; seen_ready = req_ready;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic xacc(input logic w, input logic [15:0] a, input logic [7:0] d);
    x_valid = 1'b1; x_we = w; x_addr = a; x_wdata = d;
    #1 seen_ext = ext_req;
    @(posedge clk); @(negedge clk);
    x_valid = 1'b0; x_we = 1'b0;
  endtask

  function automatic logic [7:0] ipat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  function automatic logic [7:0] xpat(input int a);
    return 8'(a * 13 + (a >> 3) + 5);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got %0d cycles exp fewer", 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0; req_bank = '0;
    req_we = 1'b0; req_wdata = '0; req_bitop = '0; req_wbit = 1'b0;
    x_valid = 1'b0; x_we = 1'b0; x_addr = '0; x_wdata = '0; x_extram = 1'b0; x_size = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check("R11 ready", req_ready, 1);
    check("R11 rd_valid", rd_valid, 0);
    check("R11 x_rd_valid", x_rd_valid, 0);

    // R2 indirect write and read over the whole array
    for (int a = 0; a < 256; a++) begin
      ireq(2'b10, 8'(a), 2'b00, 1'b1, ipat(a), 2'b00, 1'b0);
      model[a] = ipat(a);
    end
    for (int a = 0; a < 256; a++) begin
      ireq(2'b10, 8'(a), 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
      check("R7 ind rd_valid", rd_valid, 1);
      check("R2 ind data", rd_data, model[a]);
    end
    // R2 direct read of lower half
    for (int a = 0; a < 128; a++) begin
      ireq(2'b01, 8'(a), 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
      check("R2 dir data", rd_data, model[a]);
      check("R3 low no sfr", seen_sfr, 0);
    end
    // R3 direct upper half goes to special-register space
    for (int a = 128; a < 256; a++) begin
      ireq(2'b01, 8'(a), 2'b00, 1'b1, ~model[a], 2'b00, 1'b0);
      check("R3 sfr on write", seen_sfr, 1);
      ireq(2'b01, 8'(a), 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
      check("R3 sfr on read", seen_sfr, 1);
      check("R3 no rd_valid", rd_valid, 0);
      ireq(2'b10, 8'(a), 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
      check("R3 upper untouched", rd_data, model[a]);
    end

    // R1 register banks, read back through register and direct views
    for (int bk = 0; bk < 4; bk++)
      for (int r = 0; r < 8; r++) begin
        ireq(2'b00, 8'(r), 2'(bk), 1'b1, 8'(8'hC0 + bk * 16 + r), 2'b00, 1'b0);
        model[bk * 8 + r] = 8'(8'hC0 + bk * 16 + r);
      end
    for (int bk = 0; bk < 4; bk++)
      for (int r = 0; r < 8; r++) begin
        ireq(2'b00, 8'(r | 8'hF8), 2'(bk), 1'b0, 8'h00, 2'b00, 1'b0);
        check("R1 reg view", rd_data, model[bk * 8 + r]);
        ireq(2'b01, 8'(bk * 8 + r), 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
        check("R1 direct view", rd_data, model[bk * 8 + r]);
      end

    // R4 bit reads over the full bit window
    for (int b = 0; b < 128; b++) begin
      ireq(2'b11, 8'(b), 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
      check("R4 bit rd_valid", rd_valid, 1);
      check("R4 bit value", rd_bit, model[32 + b / 8][b % 8]);
      check("R4 byte", rd_data, model[32 + b / 8]);
    end

    // R5 R6 bit set/clear/write with stall and whole-byte readback
    for (int b = 0; b < 128; b++) begin
      logic [1:0] op;
      logic wb;
      int ba;
      op = 2'(1 + b % 3);
      wb = 1'(b % 2) ^ 1'((b / 8) % 2);
      ba = 32 + b / 8;
      ireq(2'b11, 8'(b), 2'b00, 1'b0, 8'h00, op, wb);
      check("R6 ready before", seen_ready, 1);
      check("R6 stall", req_ready, 0);
      @(posedge clk); @(negedge clk);
      check("R6 ready back", req_ready, 1);
      case (op)
        2'b01:   model[ba][b % 8] = 1'b1;
        2'b10:   model[ba][b % 8] = 1'b0;
        default: model[ba][b % 8] = wb;
      endcase
      ireq(2'b01, 8'(ba), 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
      check("R5 byte after bit op", rd_data, model[ba]);
    end
    // R5 alias: direct write then bit read
    ireq(2'b01, 8'h2A, 2'b00, 1'b1, 8'hA5, 2'b00, 1'b0);
    model[8'h2A] = 8'hA5;
    for (int p = 0; p < 8; p++) begin
      ireq(2'b11, 8'(8'h50 + p), 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
      check("R4 alias bit", rd_bit, model[8'h2A][p]);
    end

    // R11 contents survive reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 ready after reset", req_ready, 1);
    for (int a = 0; a < 256; a += 17) begin
      ireq(2'b10, 8'(a), 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
      check("R11 retained", rd_data, model[a]);
    end

    // R9 R10 full on-chip expanded array
    x_extram = 1'b0; x_size = 2'b11;
    for (int a = 0; a < 1024; a++) begin
      xacc(1'b1, 16'(a), xpat(a));
      xmodel[a] = xpat(a);
    end
    for (int a = 0; a < 1024; a++) begin
      xacc(1'b0, 16'(a), 8'h00);
      check("R9 local", seen_ext, 0);
      check("R10 x_rd_valid", x_rd_valid, 1);
      check("R10 x data", x_rd_data, xmodel[a]);
    end

    // R8 R9 routing sweep for every select and size
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 1056; a += 32) begin
          logic exp_ext;
          int aa;
          aa = (a == 1024) ? 65535 : a + (a % 64 == 32 ? 255 - 32 + 1 : 0);
          aa = (aa > 65535) ? 65535 : aa;
          exp_ext = (e == 1) || (aa >= 1024) || ((aa / 256) > s);
          x_extram = 1'(e); x_size = 2'(s);
          xacc(1'b0, 16'(aa), 8'h00);
          check(e ? "R8 route" : "R9 route", seen_ext, 32'(exp_ext));
          check("R10 no data when ext", x_rd_valid, 32'(!exp_ext));
        end
    // R8 R9 routed writes leave on-chip array untouched
    x_extram = 1'b1; x_size = 2'b11;
    xacc(1'b1, 16'h0005, 8'h00);
    check("R8 ext_we", ext_we, 0);
    x_extram = 1'b0; x_size = 2'b00;
    xacc(1'b1, 16'h0300, 8'h00);
    x_size = 2'b11;
    xacc(1'b0, 16'h0005, 8'h00);
    check("R8 untouched", x_rd_data, xmodel[5]);
    xacc(1'b0, 16'h0300, 8'h00);
    check("R9 untouched", x_rd_data, xmodel[12'h300]);

    // Concurrent ports: internal read with expanded read
    for (int a = 0; a < 256; a += 5) begin
      x_valid = 1'b1; x_we = 1'b0; x_addr = 16'(a);
      ireq(2'b10, 8'(a), 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
      x_valid = 1'b0;
      check("R7 concurrent ind", rd_data, model[a]);
      check("R10 concurrent x", x_rd_data, xmodel[a]);
    end
    // Bit write concurrent with expanded write
    x_valid = 1'b1; x_we = 1'b1; x_addr = 16'h0021; x_wdata = 8'h3C;
    ireq(2'b11, 8'h0B, 2'b00, 1'b0, 8'h00, 2'b01, 1'b0);
    x_valid = 1'b0; x_we = 1'b0;
    xmodel[8'h21] = 8'h3C;
    model[8'h21][3] = 1'b1;
    check("R6 concurrent stall", req_ready, 0);
    @(posedge clk); @(negedge clk);
    ireq(2'b10, 8'h21, 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
    check("R5 concurrent byte", rd_data, model[8'h21]);
    xacc(1'b0, 16'h0021, 8'h00);
    check("R10 concurrent xbyte", x_rd_data, xmodel[8'h21]);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule